// File: doc/BRIEF.md
# Nested Three-Level Interrupt Priority Controller

This block collects interrupt requests from four external pins and eight internal peripheral sources, groups them into eight vectors and decides, every cycle, whether the highest-ranked pending vector may interrupt the code that is running. Some vectors are shared. Vector 2 serves external pin 2 and internal source 0. Vector 3 serves pin 3 and internal source 1. Vector 6 serves internal sources 4 and 5. Vector 7 serves internal sources 6 and 7.

Three service levels exist: low, high and highest. Only the two first external pins may be raised to the highest level. All other vectors choose between low and high. A taken request is recorded in a small in-service stack, which allows nesting. A return strobe from the processor retires the most urgent active level. Stack saving and instruction sequencing belong to the processor, not to this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Vector v has address 03h + 8*v (8 bits). Pins 0 to 3 map to vectors 0 to 3. Internal sources 0,1,2,3,4,5,6,7 map to vectors 2,3,4,5,6,6,7,7.
- R2: `irq_o` is high while an enabled pending vector outranks the current service level. The edge after that, `ack_o` pulses for one cycle and `vec_addr_o` shows the taken vector's address from then on.
- R3: `vec_lvl[v]` sets the level. For vectors 0 and 1, 0 means low and 1 means highest. For vectors 2 to 7, 0 means low and 1 means high.
- R4: A vector is taken only when its level is strictly above the level in service. Among pending vectors, the higher level wins, and at equal level the lower vector number wins.
- R5: Each take pushes its level into the in-service stack. `reti` clears the most urgent active level. No take happens on an edge where `reti` is high.
- R6: Pins 0 and 1 use a 2-bit mode: 00 = rising edge, 01 = falling edge, 10 = high level, 11 = low level.
- R7: Pins 2 and 3 use a 2-bit mode: 00 = rising edge, 01 = falling edge, 10 or 11 = both edges. These pins have no level mode.
- R8: Edge and internal requests are latched whether or not they are enabled. A disabled latched request is held until it is enabled. Taking a vector clears all latched requests of that vector.
- R9: Level requests are not latched. They are re-evaluated every cycle and are taken again after `reti` while the level persists.
- R10: After reset, `irq_o`, `ack_o` and `vec_addr_o` are 0 and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 4 | Raw external request lines, already synchronous |
| int_pulse | input | 8 | Internal source request pulses |
| ext_en | input | 4 | Enable per external pin |
| int_en | input | 8 | Enable per internal source |
| ext_mode01 | input | 4 | Detection modes of pins 0 (bits 1:0) and 1 (bits 3:2) |
| ext_mode23 | input | 4 | Detection modes of pins 2 (bits 1:0) and 3 (bits 3:2) |
| vec_lvl | input | 8 | Level select per vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the processor |
| ack_o | output | 1 | One-cycle acceptance pulse |
| vec_addr_o | output | 8 | Address of the last taken vector |

## Verification
Each of the eight internal sources is fired alone, which separates a wrong source-to-vector map from a wrong address formula. Every pin mode is driven with both transitions, so a swapped polarity or a level/edge confusion shows up as a missing or extra acknowledge. Pairs of simultaneous requests at equal and unequal levels tell tie-breaking apart from level ordering. A chain of low, high and highest requests followed by successive returns shows whether the stack pops the right level, and whether blocked requests surface in the right order.

// File: rtl/nirq_pkg.sv
// Package: shared counts, rank type and source-to-vector mapping for the
// nested interrupt controller. Rank 0 means "nothing", 1 low, 2 high, 3 highest.
package nirq_pkg;
    localparam int NUM_VEC = 8;
    localparam int NUM_EXT = 4;
    localparam int NUM_INT = 8;
    localparam int VEC_W   = $clog2(NUM_VEC);

    typedef logic [1:0] rank_t;

    // Vector served by internal source i: first four one each, then pairs.
    function automatic int int_src_vec(input int i);
        return (i < 4) ? (i + 2) : (6 + (i - 4) / 2);
    endfunction

    // Rank of vector v for its select bit: vectors 0/1 reach highest, others high.
    function automatic rank_t vec_rank(input int v, input logic sel);
        if (!sel)
            return 2'd1;
        return (v < 2) ? 2'd3 : 2'd2;
    endfunction
endpackage

// File: rtl/irqc_ext_detect.sv
// Module: request detector for one external pin.
// Assumes the pin is already synchronous to clk. LEVEL_CAPABLE selects the
// variant: with levels (00 rise, 01 fall, 10 high, 11 low) or edges only
// (00 rise, 01 fall, 1x both). Edge hits latch until clr; a new hit wins.
module irqc_ext_detect #(
    parameter bit LEVEL_CAPABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    input  logic       clr,
    output logic       req
);
    logic prev_q;
    logic latch_q;
    logic rise, fall;
    logic is_level, edge_hit, level_hit;

    assign rise = pin & ~prev_q;
    assign fall = ~pin & prev_q;

    generate
        if (LEVEL_CAPABLE) begin : g_lvl
            // Decode the four-way mode including level sensing.
            always_comb begin
                is_level  = mode[1];
                edge_hit  = (mode == 2'b00) ? rise : (mode == 2'b01) ? fall : 1'b0;
                level_hit = (mode == 2'b10) ? pin : (mode == 2'b11) ? ~pin : 1'b0;
            end
        end else begin : g_edge
            // Decode the edge-only mode; both upper codes mean either edge.
            always_comb begin
                is_level  = 1'b0;
                level_hit = 1'b0;
                edge_hit  = (mode == 2'b00) ? rise :
                            (mode == 2'b01) ? fall : (rise | fall);
            end
        end
    endgenerate

    // Remember the previous pin value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin;
    end

    // Hold edge hits until the vector is taken; unused in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (is_level) latch_q <= 1'b0;
        else if (edge_hit) latch_q <= 1'b1;
        else if (clr)      latch_q <= 1'b0;
    end

    assign req = is_level ? level_hit : latch_q;

    p_level_no_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_level && $past(is_level)) |-> !latch_q);
    p_edge_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr && !is_level) |=> (latch_q || is_level));
endmodule

// File: rtl/irqc_arbiter.sv
// Module: picks the winning vector from per-vector ranks.
// Higher rank wins; ties go to the lower vector. win_valid is raised only when
// the winner's rank is strictly above cur_rank. Purely combinational.
module irqc_arbiter
    import nirq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_VEC-1:0][1:0]    vrank,
    input  rank_t                      cur_rank,
    output logic                       win_valid,
    output logic [VEC_W-1:0]           win_idx,
    output rank_t                      win_rank
);
    // Scan from the top vector down so that equal ranks leave the lowest index.
    always_comb begin
        win_rank = 2'd0;
        win_idx  = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (vrank[v] != 2'd0 && vrank[v] >= win_rank) begin
                win_rank = vrank[v];
                win_idx  = VEC_W'(v);
            end
        end
        win_valid = (win_rank > cur_rank);
    end

    generate
        for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
            p_winner_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
                win_valid |-> (vrank[v] <= vrank[win_idx]));
            p_tie_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (win_valid && (VEC_W'(v) < win_idx)) |-> (vrank[v] < vrank[win_idx]));
        end
    endgenerate
endmodule

// File: rtl/irqc_isr_stack.sv
// Module: in-service level stack, one bit per level (low, high, highest).
// A take sets its level's bit; reti clears the most urgent set bit and blocks
// the take on the same edge. cur_rank reports the most urgent active level.
module irqc_isr_stack
    import nirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take,
    input  rank_t take_rank,
    input  logic  reti,
    output rank_t cur_rank
);
    logic [2:0] isr_q;

    // Report the most urgent active level.
    always_comb begin
        if (isr_q[2])      cur_rank = 2'd3;
        else if (isr_q[1]) cur_rank = 2'd2;
        else if (isr_q[0]) cur_rank = 2'd1;
        else               cur_rank = 2'd0;
    end

    // Pop on return, push on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= 3'b000;
        end else if (reti) begin
            case (cur_rank)
                2'd3:    isr_q[2] <= 1'b0;
                2'd2:    isr_q[1] <= 1'b0;
                2'd1:    isr_q[0] <= 1'b0;
                default: isr_q <= isr_q;
            endcase
        end else if (take) begin
            case (take_rank)
                2'd3:    isr_q[2] <= 1'b1;
                2'd2:    isr_q[1] <= 1'b1;
                2'd1:    isr_q[0] <= 1'b1;
                default: isr_q <= isr_q;
            endcase
        end
    end

    p_reti_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && cur_rank != 2'd0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
    p_take_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !reti) |=> (cur_rank == $past(take_rank)));
    p_no_silent_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reti |=> (($past(isr_q) & ~isr_q) == 3'b000));
endmodule

// File: rtl/nest_irq_ctrl.sv
// Module: top of the nested interrupt controller.
// Gathers external and internal requests into eight vectors, ranks them by
// their level select, takes the winner when it outranks the level in service
// and emits an acknowledge pulse with the vector address. Inputs are assumed
// synchronous; internal sources are single-cycle pulses.
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   ext_pin,
    input  logic [NUM_INT-1:0]   int_pulse,
    input  logic [NUM_EXT-1:0]   ext_en,
    input  logic [NUM_INT-1:0]   int_en,
    input  logic [3:0]           ext_mode01,
    input  logic [3:0]           ext_mode23,
    input  logic [NUM_VEC-1:0]   vec_lvl,
    input  logic                 reti,
    output logic                 irq_o,
    output logic                 ack_o,
    output logic [ADDR_W-1:0]    vec_addr_o
);
    logic [NUM_EXT-1:0]        ext_req;
    logic [NUM_EXT-1:0]        ext_clr;
    logic [NUM_INT-1:0]        int_lat_q;
    logic [NUM_VEC-1:0]        pend;
    logic [NUM_VEC-1:0][1:0]   vrank;
    logic                      win_valid;
    logic [VEC_W-1:0]          win_idx;
    rank_t                     win_rank;
    rank_t                     cur_rank;
    logic                      take;

    assign take = win_valid & ~reti;

    generate
        for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
            logic raw_req;
            assign ext_clr[e] = take && (win_idx == VEC_W'(e));
            if (e < 2) begin : g_lv
                irqc_ext_detect #(.LEVEL_CAPABLE(1'b1)) u_det (
                    .clk(clk), .rst_n(rst_n), .pin(ext_pin[e]),
                    .mode(ext_mode01[2*e +: 2]), .clr(ext_clr[e]), .req(raw_req));
            end else begin : g_ed
                irqc_ext_detect #(.LEVEL_CAPABLE(1'b0)) u_det (
                    .clk(clk), .rst_n(rst_n), .pin(ext_pin[e]),
                    .mode(ext_mode23[2*(e-2) +: 2]), .clr(ext_clr[e]), .req(raw_req));
            end
            assign ext_req[e] = raw_req & ext_en[e];
        end

        for (genvar i = 0; i < NUM_INT; i++) begin : g_int
            localparam int MV = int_src_vec(i);
            // Latch the source pulse until its vector is taken; a new pulse wins.
            always_ff @(posedge clk) begin
                if (!rst_n)                          int_lat_q[i] <= 1'b0;
                else if (int_pulse[i])               int_lat_q[i] <= 1'b1;
                else if (take && win_idx == VEC_W'(MV)) int_lat_q[i] <= 1'b0;
            end
        end
    endgenerate

    // Merge sources into vectors and attach each vector's rank.
    always_comb begin
        pend = '0;
        for (int e = 0; e < NUM_EXT; e++)
            if (ext_req[e]) pend[e] = 1'b1;
        for (int i = 0; i < NUM_INT; i++)
            if (int_lat_q[i] && int_en[i]) pend[int_src_vec(i)] = 1'b1;
        for (int v = 0; v < NUM_VEC; v++)
            vrank[v] = pend[v] ? vec_rank(v, vec_lvl[v]) : 2'd0;
    end

    irqc_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .vrank(vrank), .cur_rank(cur_rank),
        .win_valid(win_valid), .win_idx(win_idx), .win_rank(win_rank));

    irqc_isr_stack u_isr (
        .clk(clk), .rst_n(rst_n), .take(take), .take_rank(win_rank),
        .reti(reti), .cur_rank(cur_rank));

    assign irq_o = win_valid;

    // Register the acknowledge pulse and the taken vector's address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o      <= 1'b0;
            vec_addr_o <= '0;
        end else begin
            ack_o <= take;
            if (take)
                vec_addr_o <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);
        end
    end

    p_addr_grid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (((vec_addr_o - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STEP)) == '0));
    p_no_take_on_reti_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !ack_o);
    p_ack_follows_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !reti) |=> ack_o);
endmodule

// File: tb/nest_irq_ctrl_bench.sv
// Bench: sweeps every source, every pin mode and the priority/nesting corners.
module nest_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ext_pin;
    logic [7:0] int_pulse;
    logic [3:0] ext_en;
    logic [7:0] int_en;
    logic [3:0] ext_mode01;
    logic [3:0] ext_mode23;
    logic [7:0] vec_lvl;
    logic       reti;
    logic       irq_o, ack_o;
    logic [7:0] vec_addr_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_pulse(int_pulse),
        .ext_en(ext_en), .int_en(int_en), .ext_mode01(ext_mode01),
        .ext_mode23(ext_mode23), .vec_lvl(vec_lvl), .reti(reti),
        .irq_o(irq_o), .ack_o(ack_o), .vec_addr_o(vec_addr_o));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic take_exp(input int v, input string tag);
        step;
        check({tag, " ack"}, int'(ack_o), 1);
        check({tag, " addr"}, int'(vec_addr_o), 3 + 8 * v);
    endtask

    task automatic idle_chk(input string tag);
        step;
        check({tag, " no ack"}, int'(ack_o), 0);
        check({tag, " no irq"}, int'(irq_o), 0);
    endtask

    task automatic do_reti;
        reti = 1'b1;
        step;
        reti = 1'b0;
    endtask

    task automatic fire(input logic [7:0] m);
        int_pulse = m;
        step;
        int_pulse = '0;
    endtask

    function automatic int src_vec(input int i);
        case (i)
            0: return 2; 1: return 3; 2: return 4; 3: return 5;
            4: return 6; 5: return 6; default: return 7;
        endcase
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_pin = '0; int_pulse = '0; ext_en = '1; int_en = '1;
        ext_mode01 = '0; ext_mode23 = '0; vec_lvl = '0; reti = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 irq", int'(irq_o), 0);
        check("R10 ack", int'(ack_o), 0);
        check("R10 addr", int'(vec_addr_o), 0);

        // R1/R2: every internal source alone at low level.
        for (int i = 0; i < 8; i++) begin
            fire(8'(1 << i));
            check("R2 irq raised", int'(irq_o), 1);
            take_exp(src_vec(i), "R1 source map");
            do_reti;
            check("R2 ack one cycle", int'(ack_o), 0);
            check("R8 latch cleared", int'(irq_o), 0);
        end

        // R6: pins 0 and 1, four modes each.
        for (int e = 0; e < 2; e++) begin
            ext_mode01[2*e +: 2] = 2'b00;               // rising
            ext_pin[e] = 1'b1; step;
            take_exp(e, "R6 rising"); do_reti;
            ext_pin[e] = 1'b0; idle_chk("R6 rising ignores fall");
            ext_mode01[2*e +: 2] = 2'b01;               // falling
            ext_pin[e] = 1'b1; idle_chk("R6 falling ignores rise");
            ext_pin[e] = 1'b0; step;
            take_exp(e, "R6 falling"); do_reti;
            ext_mode01[2*e +: 2] = 2'b10;               // high level
            idle_chk("R6 high level idle");
            ext_pin[e] = 1'b1;
            take_exp(e, "R6 high level");
            step; check("R4 equal level not retaken", int'(ack_o), 0);
            check("R4 irq low while same level in service", int'(irq_o), 0);
            do_reti;
            check("R9 level re-requests", int'(irq_o), 1);
            take_exp(e, "R9 level retaken");
            ext_pin[e] = 1'b0; do_reti;
            idle_chk("R9 level not latched");
            ext_mode01[2*e +: 2] = 2'b11;               // low level
            take_exp(e, "R6 low level");
            ext_pin[e] = 1'b1; do_reti;
            idle_chk("R6 low level released");
            ext_mode01[2*e +: 2] = 2'b00;
            ext_pin[e] = 1'b0; idle_chk("R6 restore");
        end

        // R7: pins 2 and 3, edge modes.
        for (int e = 2; e < 4; e++) begin
            ext_mode23[2*(e-2) +: 2] = 2'b00;
            ext_pin[e] = 1'b1; step; take_exp(e, "R7 rising"); do_reti;
            ext_pin[e] = 1'b0; idle_chk("R7 rising ignores fall");
            ext_mode23[2*(e-2) +: 2] = 2'b01;
            ext_pin[e] = 1'b1; idle_chk("R7 falling ignores rise");
            ext_pin[e] = 1'b0; step; take_exp(e, "R7 falling"); do_reti;
            ext_mode23[2*(e-2) +: 2] = 2'b10;
            ext_pin[e] = 1'b1; step; take_exp(e, "R7 both rise"); do_reti;
            ext_pin[e] = 1'b0; step; take_exp(e, "R7 both fall"); do_reti;
            ext_mode23[2*(e-2) +: 2] = 2'b11;
            ext_pin[e] = 1'b1; step; take_exp(e, "R7 mode3 rise"); do_reti;
            ext_pin[e] = 1'b0; step; take_exp(e, "R7 mode3 fall"); do_reti;
            ext_mode23[2*(e-2) +: 2] = 2'b00;
        end

        // R8: disabled request held; shared vector cleared by one take.
        int_en[3] = 1'b0;
        fire(8'h08);
        idle_chk("R8 disabled held");
        idle_chk("R8 disabled held 2");
        int_en[3] = 1'b1; #1;
        check("R8 enable releases", int'(irq_o), 1);
        take_exp(5, "R8 held request"); do_reti;
        fire(8'h30);
        take_exp(6, "R8 shared vector"); do_reti;
        idle_chk("R8 both sources cleared");

        // R4/R3: ties and levels.
        fire(8'h05);
        take_exp(2, "R4 tie lower vector");
        idle_chk("R4 equal level blocked");
        do_reti; take_exp(4, "R4 second of tie"); do_reti;
        vec_lvl[4] = 1'b1;
        fire(8'h05);
        take_exp(4, "R3 high beats low");
        check("R4 low waits under high", int'(irq_o), 0);
        do_reti; take_exp(2, "R4 low after high"); do_reti;
        vec_lvl[4] = 1'b0;

        // R5/R3: nesting through three levels.
        vec_lvl[0] = 1'b1; vec_lvl[3] = 1'b1;
        fire(8'h01); take_exp(2, "R5 low taken");
        fire(8'h02); take_exp(3, "R5 high nests");
        vec_lvl[4] = 1'b1;
        fire(8'h04);
        check("R3 high cannot nest on high", int'(irq_o), 0);
        fire(8'h08);
        check("R4 low blocked", int'(irq_o), 0);
        ext_pin[0] = 1'b1; step;
        take_exp(0, "R3 highest nests on high");
        do_reti;
        check("R5 pop highest leaves high", int'(irq_o), 0);
        do_reti;
        check("R5 pop high leaves low", int'(irq_o), 1);
        take_exp(4, "R5 high pending taken over low");
        do_reti;
        check("R5 back at low", int'(irq_o), 0);
        do_reti;
        check("R5 stack empty", int'(irq_o), 1);
        take_exp(5, "R5 last low taken");
        do_reti;
        idle_chk("R5 all retired");
        ext_pin[0] = 1'b0;
        vec_lvl = '0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule